// File: doc/BRIEF.md
# Dual-Mode Video Byte Output Unit

This block turns display bytes that a fetch engine delivers into a pixel stream. Each byte is offered on `byte_in` with a `byte_load` strobe. It is then played out one pixel per cycle in which `pix_clk_en` is high. The pixel value is a grey level on `pix_grey`. Sync timing and address generation sit outside the block.

In bitmap mode a byte carries four 2-bit pixel codes. Each code picks one of four writable grey levels from a small palette register file. In character mode the byte is a character code. The low seven bits of the code and the current scan row address an eight-pixel glyph row, which is then played out one bit per pixel at either zero or full grey. When bit 7 of the code is set, one of two treatments applies, chosen by `attr_custom`:

- The built-in glyph row is inverted, which gives reverse video.
- The row is taken from a glyph RAM instead. Software fills this RAM beforehand through its own write port.

Top module: `vid_byte_out`

## Requirements
- R1: After synchronous reset the unit holds no pending pixels, `pix_grey` is 0, and palette entries 0..3 hold the grey levels 0, 5, 10 and 15.
- R2: Whenever no pixels are pending, `pix_grey` is 0, whatever `pix_clk_en` does.
- R3: With `bitmap_sel`=1, a byte loaded while idle yields four pixels. The pixel from bits 7:6 comes first and the pixel from bits 1:0 comes last. The first pixel is visible in the cycle after the load edge, and each cycle with `pix_clk_en` high advances by one pixel.
- R4: A bitmap pixel shows palette entry `[code]`. A palette write (`pal_we`, `pal_waddr`, `pal_wdata`) changes the output from the next cycle on, including in the middle of a byte.
- R5: With `bitmap_sel`=0, a byte loaded while idle yields eight pixels, glyph bit 7 first. A glyph bit of 1 gives grey 15 and a bit of 0 gives grey 0.
- R6: A character with bit 7 clear uses the built-in glyph row `{code[6:0],1'b0} ^ {5'b0,row}`.
- R7: A character with bit 7 set and `attr_custom`=0 uses the bitwise inverse of the built-in row for `code[6:0]`.
- R8: A character with bit 7 set and `attr_custom`=1 uses glyph RAM word `{code[6:0],row}`. That word is written through `gram_we`, `gram_waddr` and `gram_wdata` and is readable from the next cycle on.
- R9: A `byte_load` while any pixel is still pending is ignored. This includes the cycle in which the last pixel is advanced. Output and remaining pixels stay unchanged.
- R10: The mode, row and bit-7 treatment are captured at load. Changing `bitmap_sel`, `row_sel` or `attr_custom` while pixels are pending does not alter them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_clk_en | input | 1 | Advance one pixel |
| byte_in | input | 8 | Display byte |
| byte_load | input | 1 | Load strobe for `byte_in` |
| bitmap_sel | input | 1 | 1 = bitmap, 0 = character |
| row_sel | input | 3 | Glyph scan row |
| attr_custom | input | 1 | Bit-7 treatment: 1 = glyph RAM, 0 = reverse video |
| pal_we | input | 1 | Palette write enable |
| pal_waddr | input | 2 | Palette entry to write |
| pal_wdata | input | 4 | Palette grey level |
| gram_we | input | 1 | Glyph RAM write enable |
| gram_waddr | input | 10 | Glyph RAM address `{code[6:0],row}` |
| gram_wdata | input | 8 | Glyph RAM row bits |
| pix_grey | output | 4 | Pixel grey level |

## Verification
Bitmap bytes with ascending codes (0x1B), descending codes (0xE4) and all-equal codes (0xFF, 0x00) separate a wrong field order from a wrong palette index. Character codes are run with bit 7 clear, set under reverse video, and set under the glyph-RAM bank, at several rows. Because the three glyph sources give different rows for the same low code, each source is told apart. Loads that arrive mid-byte or on the last advance, palette writes mid-byte, and mode or row changes while shifting show whether state is captured only at a load accepted while idle.

// File: rtl/vbo_pkg.sv
package vbo_pkg;

    localparam int BYTE_W = 8;
    localparam int CODE_W = 7;
    localparam int ROW_W  = 3;
    localparam int BPP    = 2;
    localparam int NCODES = 1 << BPP;

    typedef enum logic {
        PM_CHAR   = 1'b0,
        PM_BITMAP = 1'b1
    } pix_mode_e;

    typedef struct packed {
        pix_mode_e          mode;
        logic [BYTE_W-1:0]  bits;
    } load_word_t;

    // built-in glyph row: code shifted left, row folded into low bits
    function automatic logic [BYTE_W-1:0] rom_row(
        input logic [CODE_W-1:0] code,
        input logic [ROW_W-1:0]  row
    );
        return {code, 1'b0} ^ {{(BYTE_W-ROW_W){1'b0}}, row};
    endfunction

endpackage

// File: rtl/vbo_palette.sv
module vbo_palette #(
    parameter int GREY_W = 4,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [GREY_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [GREY_W-1:0] rdata
);
    localparam int N    = 1 << IDX_W;
    localparam int FULL = (1 << GREY_W) - 1;

    logic [GREY_W-1:0] ent [N];

    generate
        for (genvar i = 0; i < N; i++) begin : g_ent
            localparam logic [GREY_W-1:0] INIT = GREY_W'((i * FULL) / (N - 1));
            always_ff @(posedge clk) begin
                if (rst)
                    ent[i] <= INIT;
                else if (we && waddr == IDX_W'(i))
                    ent[i] <= wdata;
            end
        end
    endgenerate

    assign rdata = ent[ridx];
endmodule

// File: rtl/vbo_glyph.sv
module vbo_glyph
    import vbo_pkg::*;
(
    input  logic                    clk,
    input  logic                    we,
    input  logic [CODE_W+ROW_W-1:0] waddr,
    input  logic [BYTE_W-1:0]       wdata,
    input  logic [BYTE_W-1:0]       code,
    input  logic [ROW_W-1:0]        row,
    input  logic                    use_ram,
    output logic [BYTE_W-1:0]       glyph
);
    localparam int DEPTH = 1 << (CODE_W + ROW_W);

    logic [BYTE_W-1:0] ram [DEPTH];
    logic [BYTE_W-1:0] rom_bits;
    logic [BYTE_W-1:0] ram_bits;
    logic              hi;

    always_ff @(posedge clk) begin
        if (we)
            ram[waddr] <= wdata;
    end

    assign hi       = code[BYTE_W-1];
    assign rom_bits = rom_row(code[CODE_W-1:0], row);
    assign ram_bits = ram[{code[CODE_W-1:0], row}];

    always_comb begin
        if (!hi)
            glyph = rom_bits;
        else if (use_ram)
            glyph = ram_bits;
        else
            glyph = ~rom_bits;
    end
endmodule

// File: rtl/vbo_shifter.sv
module vbo_shifter
    import vbo_pkg::*;
#(
    parameter int W     = 8,
    parameter int CNT_W = $clog2(W) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  load_word_t       lw,
    input  logic             adv,
    output logic [W-1:0]     sreg,
    output logic [CNT_W-1:0] cnt,
    output pix_mode_e        mode_q
);
    localparam logic [CNT_W-1:0] N_BM = CNT_W'(W / BPP);
    localparam logic [CNT_W-1:0] N_CH = CNT_W'(W);

    logic idle;
    assign idle = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg   <= '0;
            cnt    <= '0;
            mode_q <= PM_CHAR;
        end else if (idle) begin
            if (load) begin
                sreg   <= lw.bits;
                mode_q <= lw.mode;
                cnt    <= (lw.mode == PM_BITMAP) ? N_BM : N_CH;
            end
        end else if (adv) begin
            sreg <= (mode_q == PM_BITMAP) ? (sreg << BPP) : (sreg << 1);
            cnt  <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/vid_byte_out.sv
module vid_byte_out
    import vbo_pkg::*;
#(
    parameter int GREY_W = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    pix_clk_en,
    input  logic [BYTE_W-1:0]       byte_in,
    input  logic                    byte_load,
    input  logic                    bitmap_sel,
    input  logic [ROW_W-1:0]        row_sel,
    input  logic                    attr_custom,
    input  logic                    pal_we,
    input  logic [BPP-1:0]          pal_waddr,
    input  logic [GREY_W-1:0]       pal_wdata,
    input  logic                    gram_we,
    input  logic [CODE_W+ROW_W-1:0] gram_waddr,
    input  logic [BYTE_W-1:0]       gram_wdata,
    output logic [GREY_W-1:0]       pix_grey
);
    localparam int CNT_W = $clog2(BYTE_W) + 1;

    logic [BYTE_W-1:0] glyph_bits;
    load_word_t        lw;
    logic [BYTE_W-1:0] shift_bits;
    logic [CNT_W-1:0]  pend_cnt;
    pix_mode_e         cur_mode;
    logic [GREY_W-1:0] pal_grey;

    vbo_glyph u_glyph (
        .clk     (clk),
        .we      (gram_we),
        .waddr   (gram_waddr),
        .wdata   (gram_wdata),
        .code    (byte_in),
        .row     (row_sel),
        .use_ram (attr_custom),
        .glyph   (glyph_bits)
    );

    always_comb begin
        lw.mode = bitmap_sel ? PM_BITMAP : PM_CHAR;
        lw.bits = bitmap_sel ? byte_in : glyph_bits;
    end

    vbo_shifter #(.W(BYTE_W), .CNT_W(CNT_W)) u_shift (
        .clk    (clk),
        .rst    (rst),
        .load   (byte_load),
        .lw     (lw),
        .adv    (pix_clk_en),
        .sreg   (shift_bits),
        .cnt    (pend_cnt),
        .mode_q (cur_mode)
    );

    vbo_palette #(.GREY_W(GREY_W), .IDX_W(BPP)) u_pal (
        .clk   (clk),
        .rst   (rst),
        .we    (pal_we),
        .waddr (pal_waddr),
        .wdata (pal_wdata),
        .ridx  (shift_bits[BYTE_W-1 -: BPP]),
        .rdata (pal_grey)
    );

    always_comb begin
        if (pend_cnt == '0)
            pix_grey = '0;
        else if (cur_mode == PM_BITMAP)
            pix_grey = pal_grey;
        else
            pix_grey = {GREY_W{shift_bits[BYTE_W-1]}};
    end
endmodule

// File: rtl/vbo_chk.sv
module vbo_chk #(
    parameter int GREY_W = 4,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              byte_load,
    input logic              pix_clk_en,
    input logic              bitmap_sel,
    input logic [GREY_W-1:0] pix_grey,
    input logic [CNT_W-1:0]  cnt,
    input logic [7:0]        sreg
);
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(8));                                                      // R5
    AST_IDLE_BLANK: assert property (@(posedge clk) disable iff (rst)
        (cnt == '0) |-> (pix_grey == '0));                                      // R2
    AST_BITMAP_COUNT: assert property (@(posedge clk) disable iff (rst)
        (cnt == '0 && byte_load && bitmap_sel) |=> (cnt == CNT_W'(4)));         // R3
    AST_CHAR_COUNT: assert property (@(posedge clk) disable iff (rst)
        (cnt == '0 && byte_load && !bitmap_sel) |=> (cnt == CNT_W'(8)));        // R5
    AST_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (cnt != '0 && pix_clk_en) |=> (cnt == $past(cnt) - 1'b1));              // R3
    AST_LOAD_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (cnt != '0 && byte_load && !pix_clk_en) |=> ($stable(sreg) && $stable(cnt))); // R9
    AST_LAST_LOAD: assert property (@(posedge clk) disable iff (rst)
        (cnt == CNT_W'(1) && pix_clk_en && byte_load) |=> (cnt == '0));         // R9
endmodule

bind vid_byte_out vbo_chk #(.GREY_W(GREY_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .byte_load  (byte_load),
    .pix_clk_en (pix_clk_en),
    .bitmap_sel (bitmap_sel),
    .pix_grey   (pix_grey),
    .cnt        (pend_cnt),
    .sreg       (shift_bits)
);

// File: tb/sim_vid_byte_out.sv
`timescale 1ns/1ps
module sim_vid_byte_out;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pix_clk_en = 1'b0;
    logic [7:0] byte_in = '0;
    logic       byte_load = 1'b0;
    logic       bitmap_sel = 1'b0;
    logic [2:0] row_sel = '0;
    logic       attr_custom = 1'b0;
    logic       pal_we = 1'b0;
    logic [1:0] pal_waddr = '0;
    logic [3:0] pal_wdata = '0;
    logic       gram_we = 1'b0;
    logic [9:0] gram_waddr = '0;
    logic [7:0] gram_wdata = '0;
    logic [3:0] pix_grey;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    vid_byte_out u0 (.*);

    // fields: mode, custom, row, byte, npix, expected nibbles (first pixel in top nibble)
    localparam int NV = 7;
    localparam logic [48:0] VEC [NV] = '{
        {1'b1, 1'b0, 3'd0, 8'h1B, 4'd4, 32'h05AF_0000},  // R3 R4 R1 ascending codes
        {1'b1, 1'b0, 3'd0, 8'hE4, 4'd4, 32'hFA50_0000},  // R3 descending codes
        {1'b1, 1'b0, 3'd0, 8'hFF, 4'd4, 32'hFFFF_0000},  // R3 all same code
        {1'b0, 1'b0, 3'd3, 8'h41, 4'd8, 32'hF000_000F},  // R6 R5
        {1'b0, 1'b0, 3'd5, 8'hC1, 4'd8, 32'h0FFF_F000},  // R7 reverse video
        {1'b0, 1'b1, 3'd2, 8'h85, 4'd8, 32'hF0F0_0F0F},  // R8 glyph RAM
        {1'b0, 1'b1, 3'd2, 8'h05, 4'd8, 32'h0000_F000}   // R6 bit7 clear ignores bank
    };

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s pix_grey=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic start(input logic m, input logic c, input logic [2:0] r, input logic [7:0] b);
        @(negedge clk);
        bitmap_sel = m; attr_custom = c; row_sel = r; byte_in = b;
        byte_load = 1'b1; pix_clk_en = 1'b0;
        @(negedge clk);
        byte_load = 1'b0;
    endtask

    task automatic play(input string req, input int n, input logic [31:0] exp);
        pix_clk_en = 1'b1;
        for (int k = 0; k < n; k++) begin
            chk(req, pix_grey, exp[31-4*k -: 4]);
            @(negedge clk);
        end
        pix_clk_en = 1'b0;
        chk("R2 idle after byte", pix_grey, 4'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 reset output", pix_grey, 4'h0);
        pix_clk_en = 1'b1;
        @(negedge clk);
        chk("R2 idle with enable", pix_grey, 4'h0);
        pix_clk_en = 1'b0;

        // R8: preload glyph RAM word {code 5, row 2}
        gram_we = 1'b1; gram_waddr = {7'd5, 3'd2}; gram_wdata = 8'hA5;
        @(negedge clk);
        gram_we = 1'b0;

        for (int v = 0; v < NV; v++) begin
            start(VEC[v][48], VEC[v][47], VEC[v][46:44], VEC[v][43:36]);
            play("R3/R5/R6/R7/R8 table vector", int'(VEC[v][35:32]), VEC[v][31:0]);
        end

        // R8: rewrite RAM word and reload
        @(negedge clk);
        gram_we = 1'b1; gram_waddr = {7'd5, 3'd2}; gram_wdata = 8'h3C;
        @(negedge clk);
        gram_we = 1'b0;
        start(1'b0, 1'b1, 3'd2, 8'h85);
        play("R8 rewritten glyph RAM", 8, 32'h00FF_FF00);

        // R9: load mid-byte with enable low
        start(1'b1, 1'b0, 3'd0, 8'hE4);
        chk("R9 first pixel", pix_grey, 4'hF);
        byte_in = 8'h00; byte_load = 1'b1;
        @(negedge clk);
        byte_load = 1'b0;
        chk("R9 load during shift ignored", pix_grey, 4'hF);
        pix_clk_en = 1'b1;
        @(negedge clk); chk("R9 continues", pix_grey, 4'hA);
        @(negedge clk); chk("R9 continues", pix_grey, 4'h5);
        @(negedge clk); chk("R9 last pixel", pix_grey, 4'h0);
        byte_in = 8'hFF; byte_load = 1'b1;   // coincides with last advance
        @(negedge clk);
        byte_load = 1'b0; pix_clk_en = 1'b0;
        chk("R9 load on last advance ignored", pix_grey, 4'h0);
        @(negedge clk);
        chk("R9 still idle", pix_grey, 4'h0);

        // R10: mode/row/attr change while shifting
        start(1'b0, 1'b0, 3'd3, 8'h41);
        bitmap_sel = 1'b1; row_sel = 3'd5; attr_custom = 1'b1;
        play("R10 captured at load", 8, 32'hF000_000F);

        // R4: palette write mid-byte
        start(1'b1, 1'b0, 3'd0, 8'h00);
        chk("R4 palette default entry 0", pix_grey, 4'h0);
        pal_we = 1'b1; pal_waddr = 2'd0; pal_wdata = 4'h7; pix_clk_en = 1'b1;
        @(negedge clk);
        pal_we = 1'b0;
        chk("R4 palette write next pixel", pix_grey, 4'h7);
        @(negedge clk); chk("R4 palette persists", pix_grey, 4'h7);
        @(negedge clk); chk("R4 palette persists", pix_grey, 4'h7);
        @(negedge clk);
        pix_clk_en = 1'b0;
        chk("R2 idle after palette test", pix_grey, 4'h0);

        // R1: reset restores palette defaults
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R1 output after reset", pix_grey, 4'h0);
        start(1'b1, 1'b0, 3'd0, 8'h1B);
        play("R1 palette defaults after reset", 4, 32'h05AF_0000);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule